// File: doc/BRIEF.md
# Cartridge-Port to ISA I/O Bridge

This block lets a host whose expansion connector can only read (address lines, a 16-bit read data bus and two window selects) drive an 8-bit ISA-style I/O bus. Because the host cannot present write data, it encodes the byte to be written into the address lines of an ordinary read. The bridge picks the transfer direction from the window select that is active. It takes the ISA register offset and the write byte from fixed address fields and runs a complete ISA strobe cycle. While that cycle runs it holds the host in wait.

For a peripheral with a 16-bit buffer, a wide mode builds a word write from two host accesses. A read-window access does a 16-bit read and also keeps its address byte as the pending low half. The next write-window access supplies the high half and issues a single 16-bit write.

Top module: `cartport_isa_bridge`

## Requirements
- R1: The ISA address of every cycle is 0x300 with its five low bits replaced by host_addr[13:9]. No other host bit reaches the ISA address.
- R2: An access on host_sel_a alone runs an ISA read with isa_ior_n low. An access on host_sel_b alone runs an ISA write with isa_iow_n low. The two strobes are never low together.
- R3: A byte write drives host_addr[8:1] onto isa_wdata[7:0] with isa_wdata[15:8] at zero. Reads drive isa_wdata to zero.
- R4: A byte read returns the ISA byte isa_rdata[7:0] on host_rdata[15:8] with host_rdata[7:0] at zero. isa_rdata is sampled in the last strobe clock. A write leaves host_rdata unchanged.
- R5: Each strobe stays low for exactly STB_CLKS clocks (default 4). isa_addr and isa_wdata are stable for one clock before the strobe falls and for one clock after it rises.
- R6: host_ready is high when idle. It goes low from the clock after an access is accepted and stays low for STB_CLKS+2 clocks.
- R7: A window select seen while a cycle is in progress is ignored. An access with both selects high at once is ignored. Neither starts an ISA cycle.
- R8: In wide mode a read-window access runs a 16-bit read with isa_word high and returns all of isa_rdata on host_rdata. It also latches host_addr[8:1] as a pending low byte.
- R9: In wide mode a write-window access with a pending low byte runs one 16-bit write: isa_wdata = {host_addr[8:1], pending byte} with isa_word high. It then discards the pending byte.
- R10: A write-window access with no pending low byte runs a plain byte write with isa_word low.
- R11: wide_mode is used only at the moment an access is accepted. Changing it during a cycle does not alter that cycle. A read-window access accepted in byte mode latches no pending byte.
- R12: After reset both strobes are high, host_ready is high, host_rdata is zero and no low byte is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_a | input | 1 | Read-window select |
| host_sel_b | input | 1 | Write-window select |
| host_addr | input | 13 | Host address bits 13..1 |
| wide_mode | input | 1 | Static 16-bit write mode select |
| host_rdata | output | 16 | Data returned to the host |
| host_ready | output | 1 | High when the host may complete/start an access |
| isa_addr | output | 10 | ISA I/O address |
| isa_wdata | output | 16 | ISA write data (upper byte used only for word cycles) |
| isa_rdata | input | 16 | ISA read data |
| isa_ior_n | output | 1 | ISA read strobe, active low |
| isa_iow_n | output | 1 | ISA write strobe, active low |
| isa_word | output | 1 | High when the current/last cycle is 16 bits wide |

## Verification
Three things can meet in one clock: a new window select, a cycle still in flight, and a change of the wide-mode input. The bench raises a second select in the first busy clock and flips wide_mode in the same clock. A scoreboard then confirms that exactly one strobe appears, with the address, data and width fixed when the first access was accepted. The bench also checks that the wait period keeps its full length.

// File: rtl/cib_pkg.sv
package cib_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_STROBE = 2'd2,
      ST_HOLD   = 2'd3
   } cib_state_e;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = 16;
endpackage

// File: rtl/cib_decode.sv
module cib_decode
   import cib_pkg::*;
#(
   parameter int unsigned HADDR_W = 13,
   parameter int unsigned OFS_LSB = 9,
   parameter int unsigned OFS_W   = 5,
   parameter int unsigned DAT_LSB = 1,
   parameter int unsigned ISA_AW  = 10,
   parameter logic [ISA_AW-1:0] ISA_BASE = 10'h300
) (
   input  logic [HADDR_W:1]    host_addr,
   output logic [ISA_AW-1:0]   dec_addr,
   output logic [BYTE_W-1:0]   dec_byte
);
   localparam int unsigned PAD_W = ISA_AW - OFS_W;

   generate
      if (OFS_W >= ISA_AW) begin : g_bad_width
         $error("offset field must be narrower than the ISA address");
      end
      if ((ISA_BASE % (1 << OFS_W)) != 0) begin : g_bad_base
         $error("ISA base must be aligned to the offset field");
      end
      if (OFS_LSB + OFS_W - 1 > HADDR_W || DAT_LSB + BYTE_W - 1 > HADDR_W) begin : g_bad_field
         $error("decoded fields exceed the host address width");
      end
   endgenerate

   logic [OFS_W-1:0] ofs;
   assign ofs      = host_addr[OFS_LSB +: OFS_W];
   assign dec_byte = host_addr[DAT_LSB +: BYTE_W];
   assign dec_addr = ISA_BASE | {{PAD_W{1'b0}}, ofs};
endmodule

// File: rtl/cib_wide_latch.sv
module cib_wide_latch
   import cib_pkg::*;
#(
   parameter bit WIDE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              acc_write,
   input  logic              wide_mode,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [BYTE_W-1:0] lo_byte,
   output logic              lo_valid
);
   generate
      if (WIDE_EN) begin : g_latch
         logic [BYTE_W-1:0] lo_q;
         logic              vld_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q  <= '0;
               vld_q <= 1'b0;
            end else if (accept) begin
               if (acc_write) begin
                  vld_q <= 1'b0;
               end else if (wide_mode) begin
                  lo_q  <= byte_in;
                  vld_q <= 1'b1;
               end
            end
         end

         assign lo_byte  = lo_q;
         assign lo_valid = vld_q;

         // R9: a write-window access always consumes the pending byte
         assert_valid_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && acc_write) |=> !lo_valid);
         // R8 / R11: a wide read-window access leaves a pending byte equal to its address byte
         assert_valid_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && !acc_write && wide_mode) |=> (lo_valid && lo_byte == $past(byte_in)));
         // R11: a byte-mode read-window access does not create a pending byte
         assert_no_set_bytemode_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && !acc_write && !wide_mode && !lo_valid) |=> !lo_valid);
      end else begin : g_none
         assign lo_byte  = '0;
         assign lo_valid = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cib_seq.sv
module cib_seq
   import cib_pkg::*;
#(
   parameter int unsigned STB_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic cyc_write,
   output logic accept,
   output logic last_strobe,
   output logic host_ready,
   output logic ior_n,
   output logic iow_n
);
   localparam int unsigned CNT_W = (STB_CLKS < 2) ? 1 : $clog2(STB_CLKS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STB_CLKS - 1);

   generate
      if (STB_CLKS < 1) begin : g_bad_len
         $error("strobe length must be at least one clock");
      end
   endgenerate

   cib_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   assign accept      = req && (state_q == ST_IDLE);
   assign last_strobe = (state_q == ST_STROBE) && (cnt_q == CNT_LAST);
   assign host_ready  = (state_q == ST_IDLE);
   assign ior_n       = !((state_q == ST_STROBE) && !cyc_write);
   assign iow_n       = !((state_q == ST_STROBE) &&  cyc_write);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE:   if (accept) state_q <= ST_SETUP;
            ST_SETUP: begin
               state_q <= ST_STROBE;
               cnt_q   <= '0;
            end
            ST_STROBE: begin
               if (cnt_q == CNT_LAST) state_q <= ST_HOLD;
               else                   cnt_q   <= cnt_q + 1'b1;
            end
            ST_HOLD:   state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   // independent run-length counter for the strobe window
   logic [CNT_W:0] chk_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     chk_run_q <= '0;
      else if (state_q == ST_STROBE)  chk_run_q <= chk_run_q + 1'b1;
      else if (state_q == ST_IDLE)    chk_run_q <= '0;
   end

   assert_strobe_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD) |-> (chk_run_q == (CNT_W+1)'(STB_CLKS)));
   assert_busy_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && state_q != ST_IDLE) |=> (state_q != ST_SETUP));
endmodule

// File: rtl/cartport_isa_bridge.sv
module cartport_isa_bridge
   import cib_pkg::*;
#(
   parameter int unsigned HADDR_W  = 13,
   parameter int unsigned OFS_LSB  = 9,
   parameter int unsigned OFS_W    = 5,
   parameter int unsigned DAT_LSB  = 1,
   parameter int unsigned ISA_AW   = 10,
   parameter logic [ISA_AW-1:0] ISA_BASE = 10'h300,
   parameter int unsigned STB_CLKS = 4,
   parameter bit          WIDE_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_sel_a,
   input  logic               host_sel_b,
   input  logic [HADDR_W:1]   host_addr,
   input  logic               wide_mode,
   output logic [WORD_W-1:0]  host_rdata,
   output logic               host_ready,
   output logic [ISA_AW-1:0]  isa_addr,
   output logic [WORD_W-1:0]  isa_wdata,
   input  logic [WORD_W-1:0]  isa_rdata,
   output logic               isa_ior_n,
   output logic               isa_iow_n,
   output logic               isa_word
);
   logic [ISA_AW-1:0] dec_addr;
   logic [BYTE_W-1:0] dec_byte;
   logic              req, acc_write, accept, last_strobe;
   logic [BYTE_W-1:0] lo_byte;
   logic              lo_valid;

   logic [ISA_AW-1:0] addr_q;
   logic [WORD_W-1:0] wdata_q, rdata_q;
   logic              write_q, word_q;

   // exactly one window select makes an access; both together is rejected
   assign req       = host_sel_a ^ host_sel_b;
   assign acc_write = host_sel_b;

   cib_decode #(
      .HADDR_W (HADDR_W), .OFS_LSB (OFS_LSB), .OFS_W (OFS_W),
      .DAT_LSB (DAT_LSB), .ISA_AW (ISA_AW), .ISA_BASE (ISA_BASE)
   ) u_decode (
      .host_addr (host_addr),
      .dec_addr  (dec_addr),
      .dec_byte  (dec_byte)
   );

   cib_wide_latch #(.WIDE_EN (WIDE_EN)) u_wide (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .acc_write (acc_write),
      .wide_mode (wide_mode),
      .byte_in   (dec_byte),
      .lo_byte   (lo_byte),
      .lo_valid  (lo_valid)
   );

   cib_seq #(.STB_CLKS (STB_CLKS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (req),
      .cyc_write   (write_q),
      .accept      (accept),
      .last_strobe (last_strobe),
      .host_ready  (host_ready),
      .ior_n       (isa_ior_n),
      .iow_n       (isa_iow_n)
   );

   logic acc_word;
   assign acc_word = WIDE_EN && wide_mode && (!acc_write || lo_valid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= ISA_BASE;
         wdata_q <= '0;
         write_q <= 1'b0;
         word_q  <= 1'b0;
      end else if (accept) begin
         addr_q  <= dec_addr;
         write_q <= acc_write;
         word_q  <= acc_word;
         if (!acc_write)    wdata_q <= '0;
         else if (acc_word) wdata_q <= {dec_byte, lo_byte};
         else               wdata_q <= {{(WORD_W-BYTE_W){1'b0}}, dec_byte};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (last_strobe && !write_q) begin
         if (word_q) rdata_q <= isa_rdata;
         else        rdata_q <= {isa_rdata[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
      end
   end

   assign isa_addr   = addr_q;
   assign isa_wdata  = wdata_q;
   assign host_rdata = rdata_q;
   assign isa_word   = word_q;

   assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!isa_ior_n && !isa_iow_n));
   assert_setup_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(isa_ior_n) || $fell(isa_iow_n)) |-> ($stable(isa_addr) && $stable(isa_wdata)));
   assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(isa_ior_n) || $rose(isa_iow_n)) |=> ($stable(isa_addr) && $stable(isa_wdata)));
   assert_wait_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!isa_ior_n || !isa_iow_n) |-> !host_ready);
   assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ready && (host_sel_a ^ host_sel_b)) |=> !host_ready);
endmodule

// File: tb/cartport_isa_bridge_bench.sv
module cartport_isa_bridge_bench;
   localparam int STB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel_a = 1'b0, host_sel_b = 1'b0;
   logic [13:1] host_addr = '0;
   logic        wide_mode = 1'b0;
   logic [15:0] host_rdata;
   logic        host_ready;
   logic [9:0]  isa_addr;
   logic [15:0] isa_wdata;
   logic [15:0] isa_rdata = '0;
   logic        isa_ior_n, isa_iow_n, isa_word;

   always #10 clk = ~clk;

   cartport_isa_bridge u_cartport_isa_bridge (
      .clk (clk), .rst_n (rst_n), .host_sel_a (host_sel_a), .host_sel_b (host_sel_b),
      .host_addr (host_addr), .wide_mode (wide_mode), .host_rdata (host_rdata),
      .host_ready (host_ready), .isa_addr (isa_addr), .isa_wdata (isa_wdata),
      .isa_rdata (isa_rdata), .isa_ior_n (isa_ior_n), .isa_iow_n (isa_iow_n),
      .isa_word (isa_word)
   );

   typedef struct {
      bit          wr;
      bit          word;
      logic [9:0]  addr;
      logic [15:0] wdata;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0, fails = 0, strobes_seen = 0, strobes_exp = 0;
   bit   exp_valid = 1'b0;
   logic [7:0]  exp_lo = '0;
   logic [15:0] exp_rdata = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
      end
   endtask

   // monitor: compares each ISA cycle against the scoreboard queue
   bit         prev_stb = 1'b0, stb;
   int         run = 0;
   logic [9:0] addr_prev = '0, stb_addr = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         stb = !isa_ior_n || !isa_iow_n;
         if (stb && !prev_stb) begin
            chk(isa_addr == addr_prev, "R5", "address setup", 32'(isa_addr), 32'(addr_prev));
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7", "unexpected ISA cycle", 32'(isa_addr), 0);
            end else begin
               exp_t it;
               it = exp_q.pop_front();
               strobes_seen++;
               chk(isa_addr == it.addr, "R1", {it.tag, " address"}, 32'(isa_addr), 32'(it.addr));
               chk(isa_iow_n == !it.wr && isa_ior_n == it.wr, "R2", {it.tag, " direction"},
                   {30'd0, isa_ior_n, isa_iow_n}, {30'd0, it.wr, !it.wr});
               chk(isa_wdata == it.wdata, "R3", {it.tag, " write data"}, 32'(isa_wdata), 32'(it.wdata));
               chk(isa_word == it.word, "R8", {it.tag, " width"}, 32'(isa_word), 32'(it.word));
            end
            run = 1;
            stb_addr = isa_addr;
         end else if (stb) begin
            run++;
         end
         if (!stb && prev_stb) begin
            chk(run == STB, "R5", "strobe length", 32'(run), STB);
            chk(isa_addr == stb_addr, "R5", "address hold", 32'(isa_addr), 32'(stb_addr));
         end
         prev_stb  = stb;
         addr_prev = isa_addr;
      end
   end

   // driver: one host access; pushes the expected ISA cycle and checks the host side
   task automatic access(input bit sa, input bit sb, input logic [4:0] ofs, input logic [7:0] byt,
                         input logic [15:0] rd, input bit flip_mode, input bit poke,
                         input string tag);
      bit   accepted;
      int   low;
      exp_t it;
      @(negedge clk);
      isa_rdata  = rd;
      host_addr  = {ofs, byt};
      host_sel_a = sa;
      host_sel_b = sb;
      accepted   = sa ^ sb;
      if (accepted) begin
         it.wr    = sb;
         it.word  = wide_mode && (!sb || exp_valid);
         it.addr  = 10'h300 | {5'd0, ofs};
         it.wdata = !sb ? 16'h0000 : (it.word ? {byt, exp_lo} : {8'h00, byt});
         it.tag   = tag;
         exp_q.push_back(it);
         strobes_exp++;
         if (sb) exp_valid = 1'b0;
         else if (wide_mode) begin exp_valid = 1'b1; exp_lo = byt; end
         if (!sb) exp_rdata = it.word ? rd : {rd[7:0], 8'h00};
      end
      @(negedge clk);
      host_sel_a = 1'b0;
      host_sel_b = 1'b0;
      if (!accepted) begin
         chk(host_ready == 1'b1, "R7", {tag, " rejected access keeps ready"}, 32'(host_ready), 1);
         repeat (STB + 3) @(negedge clk);
      end else begin
         low = 0;
         while (!host_ready && low < 100) begin
            low++;
            if (low == 1) begin
               if (poke) begin host_sel_a = 1'b1; host_addr = 13'h1FFF; end
               if (flip_mode) wide_mode = !wide_mode;
            end else begin
               host_sel_a = 1'b0;
            end
            @(negedge clk);
         end
         host_sel_a = 1'b0;
         chk(low == STB + 2, "R6", {tag, " wait length"}, 32'(low), STB + 2);
         chk(host_rdata == exp_rdata, sb ? "R4" : (wide_mode ^ flip_mode ? "R8" : "R4"),
             {tag, " host data"}, 32'(host_rdata), 32'(exp_rdata));
      end
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(host_ready == 1'b1, "R12", "ready after reset", 32'(host_ready), 1);
      chk(isa_ior_n && isa_iow_n, "R12", "strobes after reset", {30'd0, isa_ior_n, isa_iow_n}, 3);
      chk(host_rdata == 16'h0, "R12", "host data after reset", 32'(host_rdata), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      access(1, 0, 5'h05, 8'h00, 16'h12A5, 0, 0, "R4 byte read");
      access(0, 1, 5'h1F, 8'hC3, 16'hFFFF, 0, 0, "R3 byte write");
      access(1, 0, 5'h00, 8'hFF, 16'h00FF, 0, 0, "R1 offset zero read");
      access(0, 1, 5'h0A, 8'h81, 16'h0000, 0, 1, "R7 busy poke");
      access(1, 1, 5'h03, 8'h11, 16'h0000, 0, 0, "R7 both selects");
      wide_mode = 1'b1;
      access(0, 1, 5'h04, 8'h5A, 16'h0000, 0, 0, "R10 write without low byte");
      access(1, 0, 5'h02, 8'h34, 16'hBEEF, 0, 0, "R8 wide read");
      access(0, 1, 5'h02, 8'h12, 16'h0000, 0, 0, "R9 word write");
      access(0, 1, 5'h02, 8'h77, 16'h0000, 0, 0, "R9 pending consumed");
      access(1, 0, 5'h06, 8'h9A, 16'h0102, 0, 0, "R8 second wide read");
      access(0, 1, 5'h06, 8'h56, 16'h0000, 1, 1, "R11 mode drop mid-cycle");
      access(1, 0, 5'h07, 8'h44, 16'hCD3E, 1, 0, "R11 mode raise mid-cycle");
      access(0, 1, 5'h07, 8'h66, 16'h0000, 0, 0, "R11 no byte from byte-mode read");

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R7", "scoreboard drained", 32'(exp_q.size()), 0);
      chk(strobes_seen == strobes_exp, "R7", "ISA cycle count", 32'(strobes_seen), 32'(strobes_exp));
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule